// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Wrapper

This block sits between the raw pins of a logic core and the core itself and freezes the core while the board asks for power-down. An arming bit turns the feature on. While it is armed, a high level on either of two sleep-request pins blocks the pin inputs, the core clock enables and the output path. The core then keeps its state, and the output pins keep the values and drive states they had when the request arrived. A pin that was not driven (high-impedance) stays not driven.

Each input pin has a keeper. When the pin's driven flag is low, the core sees the level that was last driven onto that pin, so an undriven pin never reaches the core as an unknown level. When both sleep pins are low again, a recovery counter runs for a fixed number of system-clock cycles before inputs, clock enables and outputs are released. A new request during that interval puts the block back to sleep at once and the count starts over when the request goes away. When the feature is not armed, the two sleep pins are ordinary inputs that are passed on to the core, and nothing is ever blocked.

All core-side and pin-side outputs are registered on `clk` and are reset synchronously by `rst`.

Top module: `pdn_hold_wrap`

## Requirements
- R1: For the cycle after a clock edge with `rst` high, `core_ce`, `core_in`, `pin_out`, `pin_oe`, `pd_a_thru` and `pd_b_thru` are all zero. A zero in `pin_oe` means the pin is high-impedance.
- R2: When `pd_en` is low, the sleep pins have no effect. After each edge, `core_in` equals the keeper-resolved input sampled at that edge, `core_ce` equals `ce_req`, `pin_out` and `pin_oe` equal `core_out` and `core_oe`, and `pd_a_thru` and `pd_b_thru` equal `pd_a` and `pd_b`.
- R3: When `pd_en` is high at an edge, `pd_a_thru` and `pd_b_thru` are zero after that edge, so the sleep pins do not reach the core as logic inputs.
- R4: If `pd_en` is high at an edge and `pd_a` or `pd_b` is high, then after that edge `core_ce` is all zero and `core_in` keeps the value it had before the edge.
- R5: Through power-down and recovery, `pin_out` and `pin_oe` hold the values they had when the request arrived. A bit of `pin_oe` that was zero stays zero.
- R6: For a bit whose `pin_drv` is low, `core_in` carries the last level sampled on that pin while `pin_drv` was high and the block was not blocked. The keepers do not capture while the block is blocked.
- R7: Call the first edge at which both sleep pins are low (or `pd_en` is low) after a request the release edge. The outputs stay held at the release edge and for WAKE_CYCLES further edges. The edge after that updates them again.
- R8: A request at any edge during recovery blocks again at once. Recovery starts over from the next release edge, with the full WAKE_CYCLES count.
- R9: Either sleep pin alone is enough to enter power-down. The two pins are combined as an OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_en | input | 1 | Arms the power-down feature |
| pd_a | input | 1 | First sleep-request pin |
| pd_b | input | 1 | Second sleep-request pin |
| pin_in | input | N_IN | Raw input pin levels |
| pin_drv | input | N_IN | Per-pin flag: 1 = pin is being driven externally |
| ce_req | input | N_CE | Requested clock enables for the core clock domains |
| core_out | input | N_OUT | Output values produced by the core |
| core_oe | input | N_OUT | Output drive enables produced by the core |
| core_in | output | N_IN | Gated, keeper-resolved inputs to the core |
| core_ce | output | N_CE | Gated clock enables to the core |
| pin_out | output | N_OUT | Held output pin values |
| pin_oe | output | N_OUT | Held output drive enables (0 = high-impedance) |
| pd_a_thru | output | 1 | `pd_a` passed to the core as a logic input when not armed |
| pd_b_thru | output | 1 | `pd_b` passed to the core as a logic input when not armed |

## Verification
Random stimulus toggles the two sleep pins separately and now and then flips the arming bit. Single-pin, overlapping and back-to-back requests therefore occur, which separates the OR of the pins (R9) and the restart during recovery (R8) from a plain wake-up. Core outputs and enables change every cycle, so a hold that lets even one bit through shows up, and so does a high-impedance bit that becomes driven (R5). Random driven flags exercise the keepers both while running and across a sleep. Directed sequences count the exact release edge and put a request in the middle of recovery.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_DOWN = 2'd1,
    PD_WAKE = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pdn_ctrl.sv
module pdn_ctrl #(
  parameter int WAKE_CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_en,
  input  logic pd_a,
  input  logic pd_b,
  output logic blk
);
  import pdn_pkg::*;

  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  pd_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            req;

  // either pin requests sleep, only while armed
  assign req = pd_en & (pd_a | pd_b);
  assign blk = req | (state_q != PD_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PD_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PD_RUN: begin
          if (req) state_q <= PD_DOWN;
        end
        PD_DOWN: begin
          if (!req) begin
            state_q <= PD_WAKE;
            cnt_q   <= '0;
          end
        end
        PD_WAKE: begin
          if (req) begin
            state_q <= PD_DOWN;
            cnt_q   <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= PD_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PD_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pdn_keeper.sv
module pdn_keeper #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blk,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] pin_drv,
  output logic [N-1:0] eff
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic lvl_q;
    always_ff @(posedge clk) begin
      if (rst)                      lvl_q <= 1'b0;
      else if (pin_drv[i] && !blk)  lvl_q <= pin_in[i];
    end
    assign eff[i] = pin_drv[i] ? pin_in[i] : lvl_q;
  end
endmodule

// File: rtl/pdn_hold_reg.sv
module pdn_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/pdn_hold_wrap.sv
module pdn_hold_wrap #(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 8,
  parameter int N_CE        = 2,
  parameter int WAKE_CYCLES = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_en,
  input  logic             pd_a,
  input  logic             pd_b,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_IN-1:0]  pin_drv,
  input  logic [N_CE-1:0]  ce_req,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_CE-1:0]  core_ce,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic             pd_a_thru,
  output logic             pd_b_thru
);
  logic            blk;
  logic [N_IN-1:0] eff_in;

  pdn_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .pd_en(pd_en), .pd_a(pd_a), .pd_b(pd_b), .blk(blk)
  );

  pdn_keeper #(.N(N_IN)) u_keep (
    .clk(clk), .rst(rst), .blk(blk),
    .pin_in(pin_in), .pin_drv(pin_drv), .eff(eff_in)
  );

  pdn_hold_reg #(.W(N_IN)) u_in_hold (
    .clk(clk), .rst(rst), .upd(!blk), .d(eff_in), .q(core_in)
  );

  pdn_hold_reg #(.W(N_OUT)) u_out_hold (
    .clk(clk), .rst(rst), .upd(!blk), .d(core_out), .q(pin_out)
  );

  pdn_hold_reg #(.W(N_OUT)) u_oe_hold (
    .clk(clk), .rst(rst), .upd(!blk), .d(core_oe), .q(pin_oe)
  );

  // clock enables forced off while blocked
  always_ff @(posedge clk) begin
    if (rst) core_ce <= '0;
    else     core_ce <= blk ? '0 : ce_req;
  end

  // sleep pins reach the core only when the feature is not armed
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_a_thru <= 1'b0;
      pd_b_thru <= 1'b0;
    end else begin
      pd_a_thru <= pd_en ? 1'b0 : pd_a;
      pd_b_thru <= pd_en ? 1'b0 : pd_b;
    end
  end
endmodule

// File: rtl/pdn_hold_chk.sv
module pdn_hold_chk #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CE  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             pd_en,
  input logic             pd_a,
  input logic             pd_b,
  input logic [N_IN-1:0]  core_in,
  input logic [N_CE-1:0]  core_ce,
  input logic [N_OUT-1:0] pin_out,
  input logic [N_OUT-1:0] pin_oe,
  input logic             pd_a_thru,
  input logic             pd_b_thru
);
  p_ce_off_r4: assert property (@(posedge clk) disable iff (rst)
    (pd_en && (pd_a || pd_b)) |=> (core_ce == '0));

  p_in_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pd_en && (pd_a || pd_b)) |=> $stable(core_in));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pd_en && (pd_a || pd_b)) |=> ($stable(pin_out) && $stable(pin_oe)));

  p_hiz_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (pd_en && (pd_a || pd_b) && (pin_oe == '0)) |=> (pin_oe == '0));

  p_thru_block_r3: assert property (@(posedge clk) disable iff (rst)
    pd_en |=> (!pd_a_thru && !pd_b_thru));

  p_thru_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_en |=> ((pd_a_thru == $past(pd_a)) && (pd_b_thru == $past(pd_b))));

  p_single_pin_r9: assert property (@(posedge clk) disable iff (rst)
    (pd_en && pd_b && !pd_a) |=> (core_ce == '0));
endmodule

bind pdn_hold_wrap pdn_hold_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CE(N_CE)) i_chk (
  .clk(clk), .rst(rst), .pd_en(pd_en), .pd_a(pd_a), .pd_b(pd_b),
  .core_in(core_in), .core_ce(core_ce), .pin_out(pin_out), .pin_oe(pin_oe),
  .pd_a_thru(pd_a_thru), .pd_b_thru(pd_b_thru)
);

// File: tb/test_pdn_hold_wrap.sv
`timescale 1ns/1ps
module test_pdn_hold_wrap;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int NC = 2;
  localparam int W  = 20;

  logic clk = 1'b0;
  logic rst;
  logic pd_en, pd_a, pd_b;
  logic [NI-1:0] pin_in, pin_drv;
  logic [NC-1:0] ce_req;
  logic [NO-1:0] core_out, core_oe;
  logic [NI-1:0] core_in;
  logic [NC-1:0] core_ce;
  logic [NO-1:0] pin_out, pin_oe;
  logic pd_a_thru, pd_b_thru;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string ph = "R2";

  always #2 clk = ~clk;

  pdn_hold_wrap #(.N_IN(NI), .N_OUT(NO), .N_CE(NC), .WAKE_CYCLES(W)) i_pdn_hold_wrap (
    .clk(clk), .rst(rst), .pd_en(pd_en), .pd_a(pd_a), .pd_b(pd_b),
    .pin_in(pin_in), .pin_drv(pin_drv), .ce_req(ce_req),
    .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .core_ce(core_ce), .pin_out(pin_out), .pin_oe(pin_oe),
    .pd_a_thru(pd_a_thru), .pd_b_thru(pd_b_thru)
  );

  // expected-value model built from the requirements
  int            m_st = 0;   // 0 running, 1 asleep, 2 recovering
  int            m_cnt = 0;
  logic [NI-1:0] m_keep, e_in;
  logic [NC-1:0] e_ce;
  logic [NO-1:0] e_out, e_oe;
  logic          e_ta, e_tb;

  function automatic logic [NI-1:0] resolve(logic [NI-1:0] lv, logic [NI-1:0] dv,
                                            logic [NI-1:0] kp);
    return (lv & dv) | (kp & ~dv);
  endfunction

  function automatic logic is_req(logic en, logic a, logic b);
    return en & (a | b);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_keep = '0;
      e_in = '0; e_ce = '0; e_out = '0; e_oe = '0; e_ta = 0; e_tb = 0;
    end else begin
      logic rq, held;
      rq   = is_req(pd_en, pd_a, pd_b);
      held = rq || (m_st != 0);
      if (!held) begin
        e_in   = resolve(pin_in, pin_drv, m_keep);
        m_keep = resolve(pin_in, pin_drv, m_keep);
        e_ce   = ce_req;
        e_out  = core_out;
        e_oe   = core_oe;
      end else begin
        e_ce = '0;
      end
      e_ta = pd_en ? 1'b0 : pd_a;
      e_tb = pd_en ? 1'b0 : pd_b;
      case (m_st)
        0: if (rq) m_st = 1;
        1: if (!rq) begin m_st = 2; m_cnt = 0; end
        default: begin
          if (rq) m_st = 1;
          else if (m_cnt == W - 1) m_st = 0;
          else m_cnt++;
        end
      endcase
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(ph, "core_in", 32'(core_in), 32'(e_in));
    chk(ph, "core_ce", 32'(core_ce), 32'(e_ce));
    chk(ph, "pin_out", 32'(pin_out), 32'(e_out));
    chk(ph, "pin_oe",  32'(pin_oe),  32'(e_oe));
    chk(ph, "thru",    32'({pd_b_thru, pd_a_thru}), 32'({e_tb, e_ta}));
  endtask

  task automatic rand_data();
    pin_in   = NI'($urandom);
    pin_drv  = NI'($urandom | $urandom);
    ce_req   = NC'($urandom);
    core_out = NO'($urandom);
    core_oe  = NO'($urandom);
  endtask

  // one cycle: wait for the edge, then compare at the falling edge
  task automatic step();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin : watchdog
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; pd_en = 0; pd_a = 0; pd_b = 0;
    rand_data();
    repeat (3) @(negedge clk);
    ph = "R1";
    cmp_all();
    chk("R1", "reset ce", 32'(core_ce), 32'd0);
    chk("R1", "reset oe", 32'(pin_oe), 32'd0);
    rst = 0;

    // disabled: sleep pins are ordinary inputs
    ph = "R2";
    for (int k = 0; k < 40; k++) begin
      rand_data(); pd_a = 1'($urandom); pd_b = 1'($urandom);
      step();
    end
    pd_a = 0; pd_b = 0;

    // armed, single pin b, with some outputs in high-Z
    ph = "R9";
    pd_en = 1; rand_data(); core_oe = 8'h0F; ce_req = '1;
    step();
    ph = "R3"; step();
    ph = "R9"; pd_b = 1; rand_data(); step();
    chk("R9", "ce off on pd_b only", 32'(core_ce), 32'd0);
    ph = "R5";
    for (int k = 0; k < 10; k++) begin
      rand_data(); step();
      chk("R5", "hiz half kept", 32'(pin_oe), 32'h0F);
    end

    // exact release edge count
    ph = "R7";
    pd_b = 0; ce_req = '1;
    for (int k = 0; k <= W; k++) begin
      step();
      chk("R7", "held through recovery", 32'(core_ce), 32'd0);
    end
    step();
    chk("R7", "released after count", 32'(core_ce), 32'(2'b11));

    // keeper: drive a known level, then float the pin, sleep and wake
    ph = "R6";
    pin_drv = '1; pin_in = 8'hA5; step();
    pin_drv = '0; pin_in = 8'h5A; step();
    chk("R6", "keeper level", 32'(core_in), 32'hA5);
    pd_a = 1; pin_drv = '1; pin_in = 8'hFF; step();
    pd_a = 0; pin_drv = '0;
    for (int k = 0; k < W + 3; k++) step();
    chk("R6", "keeper ignores sleep writes", 32'(core_in), 32'hA5);

    // request in mid-recovery restarts the count
    ph = "R8";
    ce_req = '1;
    pd_a = 1; step(); pd_a = 0;
    for (int k = 0; k < W / 2; k++) step();
    pd_b = 1; step(); pd_b = 0;
    for (int k = 0; k <= W; k++) begin
      step();
      chk("R8", "full count after restart", 32'(core_ce), 32'd0);
    end
    step();
    chk("R8", "release after restart", 32'(core_ce), 32'(2'b11));

    // random mix
    ph = "R4";
    for (int k = 0; k < 3000; k++) begin
      rand_data();
      if ($urandom % 40 == 0)  pd_a = ~pd_a;
      if ($urandom % 60 == 0)  pd_b = ~pd_b;
      if ($urandom % 300 == 0) pd_en = ~pd_en;
      ph = (is_req(pd_en, pd_a, pd_b)) ? "R4" : (m_st != 0 ? "R7" : "R2");
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule